// File: doc/BRIEF.md
# Slow-Tick Counter with Compare Interrupt

This block keeps a 32-bit free-running count that advances from a slow tick near 32.768 kHz. The count, its tick divider and a compare value are programmed from a much faster bus clock. Every programming write is parked in a holding register on the bus side. A toggle handshake then carries it into the slow domain. A busy flag for that register stays high until the slow side has taken the value.

A match pulse is produced in the bus domain each time the count becomes equal to the compare value. Software reads the count through a snapshot that the slow domain captures and hands across whole, so a read never returns a half-updated value. The status word holds the enable bit, a sticky flag showing that slow-clock edges have been seen, and the three busy flags.

Register selects on `addr`:
- 0: trim.
- 1: count. A write preloads the count; a read returns the snapshot.
- 2: compare.
- 3: control and status. A write sets the enable from bit 0. A read returns enable at bit 0, slow-clock-seen at bit 1, trim busy at bit 2, preload busy at bit 3 and compare busy at bit 4; the other bits read 0.

Top module: `slowtick_match_timer`

## Requirements
- R1: After reset, the status word reads 0, the count reads 0 and `match_irq` is low.
- R2: With trim value 0, the count advances by one on every slow-clock edge while enabled. With trim value N > 0, it advances once every N+1 slow-clock edges.
- R3: A write to select 1 sets status bit 3 on the next bus cycle. The bit clears by itself once the count has been loaded. A later read of select 1 then returns the written value while the count is disabled.
- R4: A write to select 0 sets status bit 2 on the next bus cycle. The bit clears by itself once the slow side holds the new trim value.
- R5: A write to select 2 sets status bit 4 on the next bus cycle. A write to select 0, 1 or 2 while that register's busy bit is high is dropped.
- R6: When the count becomes equal to the compare value, `match_irq` goes high for exactly one bus cycle. A count that stays equal over several slow edges (trim > 0) yields only one pulse.
- R7: Status bit 0 follows bit 0 of the last write to select 3. While it is 0, the count holds its value.
- R8: Status bit 1 is 0 until the first slow-clock edge after reset. It then reads 1 and stays 1 even if the slow clock stops.
- R9: The count wraps from 2^32-1 to 0 and keeps advancing.
- R10: Reads of select 0 and select 2 return the last write that was accepted for that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast register-interface clock |
| slow_clk | input | 1 | Slow tick clock, nominally 32.768 kHz |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| addr | input | 2 | Register select for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the selected register |
| match_irq | output | 1 | One-cycle compare pulse in the bus domain |

## Verification
Two behaviours are hard to reach from the ports. The first is a write that arrives while the same register's handshake is still in flight. The bench reaches it by issuing two writes to one register on back-to-back bus cycles, then reading back which value survived. The second is a count that sits on the compare value for several slow edges. The bench gets there by setting a large trim before enabling, then counting interrupt pulses over the whole dwell. Divider ratios cannot be timed exactly across the asynchronous crossing. The bench therefore sweeps trim values 0 to 3 and checks each count advance against 64 slow edges per step, within a small margin for snapshot latency.

// File: rtl/swm_pkg.sv
package swm_pkg;
   typedef enum logic [1:0] {
      SEL_TRIM  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_MATCH = 2'd2,
      SEL_CTRL  = 2'd3
   } swm_sel_e;

   localparam int ST_EN         = 0;
   localparam int ST_SEEN       = 1;
   localparam int ST_TRIM_BUSY  = 2;
   localparam int ST_CNT_BUSY   = 3;
   localparam int ST_MATCH_BUSY = 4;
   localparam int ST_BITS       = 5;
endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q <= '0;
            else        chain_q <= d;
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d};
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/swm_xfer.sv
module swm_xfer #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         src_clk,
   input  logic         dst_clk,
   input  logic         rst_n,
   input  logic         src_put,
   input  logic [W-1:0] src_data,
   output logic         src_busy,
   output logic [W-1:0] src_hold,
   output logic         dst_load,
   output logic [W-1:0] dst_data
);
   logic req_q, req_dst, ack_q, ack_src;

   always_ff @(posedge src_clk or negedge rst_n)
      if (!rst_n) begin
         req_q    <= 1'b0;
         src_hold <= '0;
      end else if (src_put && !src_busy) begin
         req_q    <= ~req_q;
         src_hold <= src_data;
      end

   swm_sync #(.STAGES(STAGES)) u_req_sync (
      .clk(dst_clk), .rst_n(rst_n), .d(req_q), .q(req_dst));

   always_ff @(posedge dst_clk or negedge rst_n)
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= req_dst;

   swm_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk(src_clk), .rst_n(rst_n), .d(ack_q), .q(ack_src));

   assign dst_load = req_dst ^ ack_q;
   assign dst_data = src_hold;
   assign src_busy = req_q ^ ack_src;
endmodule

// File: rtl/swm_prescale.sv
module swm_prescale #(
   parameter int TRIM_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [TRIM_W-1:0] trim,
   output logic              tick
);
   logic [TRIM_W-1:0] div_q;

   assign tick = en && (div_q >= trim);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)  div_q <= '0;
      else if (en) div_q <= tick ? '0 : div_q + 1'b1;
endmodule

// File: rtl/swm_core.sv
module swm_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             cmp_load,
   input  logic [CNT_W-1:0] cmp_val,
   output logic [CNT_W-1:0] count,
   output logic             evt_tgl
);
   logic [CNT_W-1:0] cmp_q;
   logic             eq, eq_q;

   assign eq = (count == cmp_q);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         count   <= '0;
         cmp_q   <= '0;
         eq_q    <= 1'b1;
         evt_tgl <= 1'b0;
      end else begin
         if (load)      count <= load_val;
         else if (tick) count <= count + 1'b1;
         if (cmp_load)  cmp_q <= cmp_val;
         eq_q <= eq;
         if (eq && !eq_q) evt_tgl <= ~evt_tgl;
      end
endmodule

// File: rtl/slowtick_match_timer.sv
module slowtick_match_timer #(
   parameter int CNT_W       = 32,
   parameter int TRIM_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit PRESCALE    = 1'b1
) (
   input  logic             bus_clk,
   input  logic             slow_clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] rd_data,
   output logic             match_irq
);
   import swm_pkg::*;

   localparam int PAD_W = CNT_W - TRIM_W;

   if (CNT_W < 8)         begin : g_bad_cnt  $error("CNT_W must be at least 8");  end
   if (TRIM_W < 1)        begin : g_bad_trim $error("TRIM_W must be positive"); end
   if (TRIM_W > CNT_W)    begin : g_bad_tw   $error("TRIM_W exceeds CNT_W");    end
   if (SYNC_STAGES < 2)   begin : g_bad_sync $error("SYNC_STAGES below 2");     end

   logic wr_trim, wr_cnt, wr_cmp, wr_ctrl;
   assign wr_trim = wr_en && (addr == SEL_TRIM);
   assign wr_cnt  = wr_en && (addr == SEL_COUNT);
   assign wr_cmp  = wr_en && (addr == SEL_MATCH);
   assign wr_ctrl = wr_en && (addr == SEL_CTRL);

   // bus-domain control state
   logic en_q, seen_q, seen_bus, evt_bus, evt_q;
   always_ff @(posedge bus_clk or negedge rst_n)
      if (!rst_n) begin
         en_q   <= 1'b0;
         seen_q <= 1'b0;
         evt_q  <= 1'b0;
      end else begin
         if (wr_ctrl) en_q <= wr_data[0];
         seen_q <= seen_q | seen_bus;
         evt_q  <= evt_bus;
      end
   assign match_irq = evt_bus ^ evt_q;

   // slow-domain control state
   logic en_slow, seen_slow;
   swm_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
      .clk(slow_clk), .rst_n(rst_n), .d(en_q), .q(en_slow));
   always_ff @(posedge slow_clk or negedge rst_n)
      if (!rst_n) seen_slow <= 1'b0;
      else        seen_slow <= 1'b1;
   swm_sync #(.STAGES(SYNC_STAGES)) u_seen_sync (
      .clk(bus_clk), .rst_n(rst_n), .d(seen_slow), .q(seen_bus));

   // trim path, present only when the prescaler is built
   logic              trim_busy, tick;
   logic [TRIM_W-1:0] trim_hold;
   generate
      if (PRESCALE) begin : g_pre
         logic              trim_load;
         logic [TRIM_W-1:0] trim_xd, trim_q;
         swm_xfer #(.W(TRIM_W), .STAGES(SYNC_STAGES)) u_trim_x (
            .src_clk(bus_clk), .dst_clk(slow_clk), .rst_n(rst_n),
            .src_put(wr_trim), .src_data(wr_data[TRIM_W-1:0]),
            .src_busy(trim_busy), .src_hold(trim_hold),
            .dst_load(trim_load), .dst_data(trim_xd));
         always_ff @(posedge slow_clk or negedge rst_n)
            if (!rst_n)         trim_q <= '0;
            else if (trim_load) trim_q <= trim_xd;
         swm_prescale #(.TRIM_W(TRIM_W)) u_div (
            .clk(slow_clk), .rst_n(rst_n), .en(en_slow), .trim(trim_q), .tick(tick));
      end else begin : g_nopre
         assign trim_busy = 1'b0;
         assign trim_hold = '0;
         assign tick      = en_slow;
      end
   endgenerate

   // preload and compare paths
   logic             cnt_busy, cnt_load, cmp_busy, cmp_load;
   logic [CNT_W-1:0] cnt_hold, cnt_xd, cmp_hold, cmp_xd;
   swm_xfer #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cnt_x (
      .src_clk(bus_clk), .dst_clk(slow_clk), .rst_n(rst_n),
      .src_put(wr_cnt), .src_data(wr_data), .src_busy(cnt_busy),
      .src_hold(cnt_hold), .dst_load(cnt_load), .dst_data(cnt_xd));
   swm_xfer #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cmp_x (
      .src_clk(bus_clk), .dst_clk(slow_clk), .rst_n(rst_n),
      .src_put(wr_cmp), .src_data(wr_data), .src_busy(cmp_busy),
      .src_hold(cmp_hold), .dst_load(cmp_load), .dst_data(cmp_xd));

   logic [CNT_W-1:0] count;
   logic             evt_tgl;
   swm_core #(.CNT_W(CNT_W)) u_core (
      .clk(slow_clk), .rst_n(rst_n), .tick(tick),
      .load(cnt_load), .load_val(cnt_xd),
      .cmp_load(cmp_load), .cmp_val(cmp_xd),
      .count(count), .evt_tgl(evt_tgl));
   swm_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
      .clk(bus_clk), .rst_n(rst_n), .d(evt_tgl), .q(evt_bus));

   // snapshot of the count carried back to the bus domain
   logic             snap_busy, snap_load;
   logic [CNT_W-1:0] snap_hold, snap_xd, rd_cnt_q;
   swm_xfer #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_snap_x (
      .src_clk(slow_clk), .dst_clk(bus_clk), .rst_n(rst_n),
      .src_put(1'b1), .src_data(count), .src_busy(snap_busy),
      .src_hold(snap_hold), .dst_load(snap_load), .dst_data(snap_xd));
   always_ff @(posedge bus_clk or negedge rst_n)
      if (!rst_n)         rd_cnt_q <= '0;
      else if (snap_load) rd_cnt_q <= snap_xd;

   logic [ST_BITS-1:0] status;
   always_comb begin
      status                = '0;
      status[ST_EN]         = en_q;
      status[ST_SEEN]       = seen_q;
      status[ST_TRIM_BUSY]  = trim_busy;
      status[ST_CNT_BUSY]   = cnt_busy;
      status[ST_MATCH_BUSY] = cmp_busy;
   end

   always_comb
      case (addr)
         SEL_TRIM:  rd_data = {{PAD_W{1'b0}}, trim_hold};
         SEL_COUNT: rd_data = rd_cnt_q;
         SEL_MATCH: rd_data = cmp_hold;
         default:   rd_data = {{(CNT_W-ST_BITS){1'b0}}, status};
      endcase
endmodule

// File: rtl/swm_checks.sv
module swm_checks #(
   parameter int CNT_W = 32
) (
   input logic             bus_clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       addr,
   input logic             match_irq,
   input logic             seen_q,
   input logic             trim_busy,
   input logic             cnt_busy,
   input logic             cmp_busy,
   input logic [CNT_W-1:0] cmp_hold
);
   import swm_pkg::*;

   p_irq_one_cycle_r6: assert property (@(posedge bus_clk) disable iff (!rst_n)
      match_irq |=> !match_irq);

   p_seen_sticky_r8: assert property (@(posedge bus_clk) disable iff (!rst_n)
      seen_q |=> seen_q);

   p_trim_busy_set_r4: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (wr_en && addr == SEL_TRIM && !trim_busy) |=> trim_busy);

   p_cnt_busy_set_r3: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (wr_en && addr == SEL_COUNT && !cnt_busy) |=> cnt_busy);

   p_cmp_busy_set_r5: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (wr_en && addr == SEL_MATCH && !cmp_busy) |=> cmp_busy);

   p_cmp_drop_r5: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (wr_en && addr == SEL_MATCH && cmp_busy) |=> $stable(cmp_hold));
endmodule

bind slowtick_match_timer swm_checks #(.CNT_W(CNT_W)) u_checks (
   .bus_clk(bus_clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
   .match_irq(match_irq), .seen_q(seen_q), .trim_busy(trim_busy),
   .cnt_busy(cnt_busy), .cmp_busy(cmp_busy), .cmp_hold(cmp_hold));

// File: tb/slowtick_match_timer_test.sv
module slowtick_match_timer_test;
   localparam int BUS_PERIOD = 10;
   localparam int SLOW_HALF  = 37;

   logic        bus_clk = 1'b0, slow_clk = 1'b0, slow_run = 1'b0;
   logic        rst_n = 1'b0, wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wr_data = '0, rd_data;
   logic        match_irq;
   int          n_cmp = 0, n_bad = 0, irq_cnt = 0;
   bit          done = 1'b0;

   slowtick_match_timer uut (
      .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .match_irq(match_irq));

   always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
   always begin
      #(SLOW_HALF);
      if (slow_run) slow_clk = ~slow_clk;
   end
   always @(negedge bus_clk) if (match_irq) irq_cnt++;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge bus_clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge bus_clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge bus_clk);
      addr = a;
      #1 d = rd_data;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 500; i++) begin
         bus_rd(2'd3, s);
         if (s[4:2] == 3'b000) break;
      end
   endtask

   task automatic slow_edges(input int n);
      repeat (n) @(posedge slow_clk);
   endtask

   logic [31:0] v, a0, b0;

   initial begin
      repeat (5) @(negedge bus_clk);
      rst_n = 1'b1;
      repeat (5) @(negedge bus_clk);
      // R1 reset state, slow clock not yet running
      bus_rd(2'd3, v); check(v == 0, "R1 status", v, 0);
      bus_rd(2'd1, v); check(v == 0, "R1 count", v, 0);
      check(match_irq == 1'b0, "R1 irq", match_irq, 0);
      check(v[1] == 1'b0, "R8 seen before clock", v[1], 0);
      slow_run = 1'b1;
      slow_edges(6);
      bus_rd(2'd3, v); check(v[1] == 1'b1, "R8 seen after clock", v[1], 1);

      // R4/R10 trim busy and readback, R5 dropped write
      bus_wr(2'd0, 32'd2);
      bus_rd(2'd3, v); check(v[2] == 1'b1, "R4 trim busy", v[2], 1);
      bus_wr(2'd0, 32'd5);
      wait_idle();
      bus_rd(2'd3, v); check(v[2] == 1'b0, "R4 trim busy clears", v[2], 0);
      bus_rd(2'd0, v); check(v == 2, "R5 trim write dropped / R10", v, 2);

      // R5 compare busy and dropped write, R10 readback
      bus_wr(2'd2, 32'h111);
      bus_rd(2'd3, v); check(v[4] == 1'b1, "R5 compare busy", v[4], 1);
      bus_wr(2'd2, 32'h222);
      wait_idle();
      bus_rd(2'd2, v); check(v == 32'h111, "R5 compare drop / R10", v, 32'h111);

      // R3 preload with count disabled, R7 enable bit
      bus_wr(2'd1, 32'h1234_5678);
      bus_rd(2'd3, v); check(v[3] == 1'b1, "R3 preload busy", v[3], 1);
      bus_wr(2'd1, 32'h0BAD);
      wait_idle();
      bus_rd(2'd3, v); check(v[3] == 1'b0, "R3 preload busy clears", v[3], 0);
      slow_edges(10);
      bus_rd(2'd1, v); check(v == 32'h1234_5678, "R3 preload value", v, 32'h1234_5678);
      bus_rd(2'd3, v); check(v[0] == 1'b0, "R7 enable low", v[0], 0);
      slow_edges(40);
      bus_rd(2'd1, v); check(v == 32'h1234_5678, "R7 hold while disabled", v, 32'h1234_5678);

      // R2 divider sweep
      for (int n = 0; n < 4; n++) begin
         bus_wr(2'd3, 32'd0);
         bus_wr(2'd0, n);
         wait_idle();
         bus_wr(2'd1, 32'd0);
         wait_idle();
         bus_wr(2'd3, 32'd1);
         bus_rd(2'd3, v); check(v[0] == 1'b1, "R7 enable set", v[0], 1);
         slow_edges(20);
         bus_rd(2'd1, a0);
         slow_edges(64 * (n + 1));
         bus_rd(2'd1, b0);
         v = b0 - a0;
         check(v >= 59 && v <= 69, $sformatf("R2 rate trim=%0d", n), v, 64);
      end

      // R9 wrap
      bus_wr(2'd3, 32'd0);
      bus_wr(2'd0, 32'd0);
      bus_wr(2'd1, 32'hFFFF_FFF8);
      wait_idle();
      bus_wr(2'd3, 32'd1);
      slow_edges(40);
      bus_rd(2'd1, v); check(v >= 32'h18 && v < 32'h40, "R9 wrap", v, 32'h20);

      // R6 compare pulse, trim 0
      bus_wr(2'd3, 32'd0);
      bus_wr(2'd1, 32'd0);
      wait_idle();
      bus_wr(2'd2, 32'd30);
      wait_idle();
      repeat (20) @(negedge bus_clk);
      irq_cnt = 0;
      bus_wr(2'd3, 32'd1);
      slow_edges(60);
      repeat (10) @(negedge bus_clk);
      check(irq_cnt == 1, "R6 one pulse trim=0", irq_cnt, 1);

      // R6 compare pulse with long dwell, trim 3
      bus_wr(2'd3, 32'd0);
      bus_wr(2'd0, 32'd3);
      bus_wr(2'd1, 32'd0);
      wait_idle();
      bus_wr(2'd2, 32'd10);
      wait_idle();
      repeat (20) @(negedge bus_clk);
      irq_cnt = 0;
      bus_wr(2'd3, 32'd1);
      slow_edges(100);
      repeat (10) @(negedge bus_clk);
      check(irq_cnt == 1, "R6 one pulse trim=3", irq_cnt, 1);

      // R8 sticky after the slow clock stops
      slow_run = 1'b0;
      repeat (100) @(negedge bus_clk);
      bus_rd(2'd3, v); check(v[1] == 1'b1, "R8 sticky", v[1], 1);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge bus_clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule